// File: doc/BRIEF.md
# Interrupt Steering Aggregator

This block gathers a parameterised set of level-sensitive interrupt lines, a multiple of 32 and at most 512. It merges them into a small number of output interrupts, one for each run of 64 consecutive inputs. Every input first passes through a two-flop synchroniser. The synchronised inputs are stored in 32-bit banks. For each input, a software-set bit can force its status high and an enable-mask bit gates it. A per-output disable and a channel-select bit in the control word then decide whether the merged level reaches the output pin.

Software uses a single-cycle 32-bit register port with address, write enable, write data, read enable and read data. Every register block is placed at an offset that scales with the bank count R = NUM_IN/32. The banks are numbered in reverse, so the lowest-numbered inputs sit in the highest-numbered bank. When NUM_IN is not a multiple of 64, the last output serves only the final 32 inputs.

Top module: `irq_steer_agg`

## Requirements
- R1: After reset, every output is 0 and every readable register returns 0.
- R2: Word offsets are as follows. Control is at 0x0. Enable-mask bank n is at 0x4+4n. Software-set bank n is at 4R+0x4+4n. Status bank n is at 8R+0x4+4n. Output disable is at 12R+0x4. Merged status is at 12R+0x8. The control, mask, set and disable registers read back what was written. Any other offset reads 0.
- R3: Input i appears in status bank R-1-(i/32) at bit i mod 32, provided its enable-mask bit is 1.
- R4: An enable-mask bit of 0 forces the matching status bit to 0 and removes that input from its output.
- R5: A software-set bit of 1 makes the matching status bit 1, provided the mask bit is 1, whatever the input level.
- R6: Output k, and bit k of the merged status register, is the OR of the status bits of inputs 64k to 64k+63. The group is clipped at NUM_IN, so with NUM_IN=96 the last output covers inputs 64 to 95 only.
- R7: When bit k of the output-disable register is 1, output k is held at 0. Merged-status bit k still shows the level before the disable.
- R8: The outputs can be 1 only while control bit CHAN_ID is 1. The other control bits do not enable any output.
- R9: An input that rises before clock edge 0 drives its output high after edge 2 and not before. Read data appears on the clock edge that samples the read enable.
- R10: Writes to the status banks and to the merged-status register change no register.
- R11: Status is level-sensitive. A status bit returns to 0 once its input falls, unless its software-set bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_IN | Level interrupt inputs, asynchronous |
| addr | input | ADDR_W | Byte address of the register port |
| we | input | 1 | Write enable |
| wdata | input | 32 | Write data |
| re | input | 1 | Read enable |
| rdata | output | 32 | Registered read data |
| irq_out | output | NOUT | Merged interrupt outputs, one per 64 inputs |

## Verification
Two events can fall in the same cycle. One is a hardware input falling. The other is a software-set write to that same bit. The bench drops input 40 on the same cycle that it writes set bank 1 bit 8. It then expects the status bit and output 0 to stay high without a gap. In the same way, an output-disable write is issued while a group input rises. The output must stay low while the merged status reads 1. All expected bank, bit and output values come from index arithmetic on the input number.

// File: rtl/irqsteer_pkg.sv
package irqsteer_pkg;

   localparam int WORD_BITS    = 32;
   localparam int GROUP_INPUTS = 64;
   localparam int MAX_INPUTS   = 512;

   function automatic int bank_count(input int n_in);
      return n_in / WORD_BITS;
   endfunction

   function automatic int out_count(input int n_in);
      return (n_in + GROUP_INPUTS - 1) / GROUP_INPUTS;
   endfunction

   // flat bit position of input i inside the bank-ordered vector
   function automatic int flat_pos(input int n_banks, input int i);
      return (n_banks - 1 - i / WORD_BITS) * WORD_BITS + (i % WORD_BITS);
   endfunction

endpackage

// File: rtl/irqsteer_sync.sv
module irqsteer_sync #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_in,
   output logic [WIDTH-1:0] sync_out
);

   logic [WIDTH-1:0] meta_q;
   logic [WIDTH-1:0] sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         meta_q <= '0;
         sync_q <= '0;
      end else begin
         meta_q <= async_in;
         sync_q <= meta_q;
      end
   end

   assign sync_out = sync_q;

endmodule

// File: rtl/irqsteer_regs.sv
module irqsteer_regs #(
   parameter int NUM_IN = 128,
   parameter int ADDR_W = 8,
   parameter int NB     = irqsteer_pkg::bank_count(NUM_IN),
   parameter int NOUT   = irqsteer_pkg::out_count(NUM_IN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic             we,
   input  logic [31:0]      wdata,
   input  logic             re,
   output logic [31:0]      rdata,
   input  logic [NB*32-1:0] status_bk,
   input  logic [NOUT-1:0]  raw_lvl,
   output logic [31:0]      ctrl,
   output logic [NB*32-1:0] mask_bk,
   output logic [NB*32-1:0] set_bk,
   output logic [NOUT-1:0]  out_dis
);

   localparam int WI     = ADDR_W - 2;
   localparam int A_MASK = 1;
   localparam int A_SET  = 1 + NB;
   localparam int A_STAT = 1 + 2 * NB;
   localparam int A_DIS  = 1 + 3 * NB;
   localparam int A_MST  = 2 + 3 * NB;

   logic [WI-1:0]      widx;
   logic [31:0]        ctrl_q;
   logic [NB*32-1:0]   mask_q;
   logic [NB*32-1:0]   set_q;
   logic [NOUT-1:0]    dis_q;
   logic [31:0]        rd_val;
   logic [31:0]        rdata_q;
   logic               ro_hit;

   assign widx = addr[ADDR_W-1:2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         mask_q <= '0;
         set_q  <= '0;
         dis_q  <= '0;
      end else if (we) begin
         if (widx == WI'(0)) ctrl_q <= wdata;
         for (int b = 0; b < NB; b++) begin
            if (widx == WI'(A_MASK + b)) mask_q[b*32 +: 32] <= wdata;
            if (widx == WI'(A_SET + b))  set_q[b*32 +: 32]  <= wdata;
         end
         if (widx == WI'(A_DIS)) dis_q <= wdata[NOUT-1:0];
      end
   end

   always_comb begin
      rd_val = '0;
      if (widx == WI'(0)) rd_val = ctrl_q;
      for (int b = 0; b < NB; b++) begin
         if (widx == WI'(A_MASK + b)) rd_val = mask_q[b*32 +: 32];
         if (widx == WI'(A_SET + b))  rd_val = set_q[b*32 +: 32];
         if (widx == WI'(A_STAT + b)) rd_val = status_bk[b*32 +: 32];
      end
      if (widx == WI'(A_DIS)) rd_val[NOUT-1:0] = dis_q;
      if (widx == WI'(A_MST)) rd_val[NOUT-1:0] = raw_lvl;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  rdata_q <= '0;
      else if (re) rdata_q <= rd_val;
   end

   assign ro_hit = (widx >= WI'(A_STAT)) && (widx < WI'(A_DIS)) || (widx == WI'(A_MST));

   AST_RO_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (we && ro_hit) |=> ($stable(mask_q) && $stable(set_q) && $stable(ctrl_q) && $stable(dis_q))); // R10

   assign rdata   = rdata_q;
   assign ctrl    = ctrl_q;
   assign mask_bk = mask_q;
   assign set_bk  = set_q;
   assign out_dis = dis_q;

endmodule

// File: rtl/irqsteer_merge.sv
module irqsteer_merge #(
   parameter int NUM_IN  = 128,
   parameter int CHAN_ID = 0,
   parameter int NB      = irqsteer_pkg::bank_count(NUM_IN),
   parameter int NOUT    = irqsteer_pkg::out_count(NUM_IN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NUM_IN-1:0] sync_in,
   input  logic [NB*32-1:0] mask_bk,
   input  logic [NB*32-1:0] set_bk,
   input  logic [31:0]      ctrl,
   input  logic [NOUT-1:0]  out_dis,
   output logic [NB*32-1:0] status_bk,
   output logic [NOUT-1:0]  raw_lvl,
   output logic [NOUT-1:0]  irq_out
);

   logic [NUM_IN-1:0] st_in;
   logic [NOUT-1:0]   out_q;
   logic              chan_en;

   for (genvar i = 0; i < NUM_IN; i++) begin : g_in
      localparam int P = irqsteer_pkg::flat_pos(NB, i);
      assign st_in[i]     = (sync_in[i] | set_bk[P]) & mask_bk[P];
      assign status_bk[P] = st_in[i];
   end

   for (genvar k = 0; k < NOUT; k++) begin : g_grp
      localparam int LO = k * irqsteer_pkg::GROUP_INPUTS;
      localparam int HI = (LO + irqsteer_pkg::GROUP_INPUTS > NUM_IN) ?
                          NUM_IN : LO + irqsteer_pkg::GROUP_INPUTS;
      assign raw_lvl[k] = |st_in[HI-1:LO];

      AST_DIS_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
         out_dis[k] |=> !irq_out[k]); // R7
      AST_OUT_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
         irq_out[k] |-> $past(raw_lvl[k])); // R6
   end

   assign chan_en = ctrl[CHAN_ID];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_q <= '0;
      else        out_q <= raw_lvl & ~out_dis & {NOUT{chan_en}};
   end

   assign irq_out = out_q;

   AST_CHAN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      !chan_en |=> (irq_out == '0)); // R8

endmodule

// File: rtl/irq_steer_agg.sv
module irq_steer_agg #(
   parameter int NUM_IN  = 128,
   parameter int CHAN_ID = 0,
   parameter int ADDR_W  = 8,
   parameter int NB      = irqsteer_pkg::bank_count(NUM_IN),
   parameter int NOUT    = irqsteer_pkg::out_count(NUM_IN)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_IN-1:0] irq_in,
   input  logic [ADDR_W-1:0] addr,
   input  logic              we,
   input  logic [31:0]       wdata,
   input  logic              re,
   output logic [31:0]       rdata,
   output logic [NOUT-1:0]   irq_out
);

   if (NUM_IN % 32 != 0 || NUM_IN < 32 || NUM_IN > irqsteer_pkg::MAX_INPUTS) begin : g_bad_in
      $error("NUM_IN must be a multiple of 32 between 32 and 512");
   end
   if (CHAN_ID < 0 || CHAN_ID > 31) begin : g_bad_chan
      $error("CHAN_ID must select a bit of the control word");
   end
   if ((12 * NB + 8) >= (1 << ADDR_W)) begin : g_bad_addr
      $error("ADDR_W too small for the register map");
   end

   logic [NUM_IN-1:0] sync_w;
   logic [NB*32-1:0]  status_w;
   logic [NB*32-1:0]  mask_w;
   logic [NB*32-1:0]  set_w;
   logic [NOUT-1:0]   raw_w;
   logic [NOUT-1:0]   dis_w;
   logic [31:0]       ctrl_w;

   irqsteer_sync #(.WIDTH(NUM_IN)) i_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .async_in (irq_in),
      .sync_out (sync_w)
   );

   irqsteer_regs #(.NUM_IN(NUM_IN), .ADDR_W(ADDR_W), .NB(NB), .NOUT(NOUT)) i_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .addr      (addr),
      .we        (we),
      .wdata     (wdata),
      .re        (re),
      .rdata     (rdata),
      .status_bk (status_w),
      .raw_lvl   (raw_w),
      .ctrl      (ctrl_w),
      .mask_bk   (mask_w),
      .set_bk    (set_w),
      .out_dis   (dis_w)
   );

   irqsteer_merge #(.NUM_IN(NUM_IN), .CHAN_ID(CHAN_ID), .NB(NB), .NOUT(NOUT)) i_merge (
      .clk       (clk),
      .rst_n     (rst_n),
      .sync_in   (sync_w),
      .mask_bk   (mask_w),
      .set_bk    (set_w),
      .ctrl      (ctrl_w),
      .out_dis   (dis_w),
      .status_bk (status_w),
      .raw_lvl   (raw_w),
      .irq_out   (irq_out)
   );

endmodule

// File: tb/test_irq_steer_agg.sv
module test_irq_steer_agg;

   localparam int N    = 96;
   localparam int R    = N / 32;
   localparam int NO   = (N + 63) / 64;
   localparam int CH   = 2;
   localparam int AW   = 8;
   localparam int A_DIS = 12 * R + 4;
   localparam int A_MST = 12 * R + 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  irq_in = '0;
   logic [AW-1:0] addr = '0;
   logic          we = 1'b0;
   logic [31:0]   wdata = '0;
   logic          re = 1'b0;
   logic [31:0]   rdata;
   logic [NO-1:0] irq_out;

   int n_checks = 0;
   int n_errors = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   irq_steer_agg #(.NUM_IN(N), .CHAN_ID(CH), .ADDR_W(AW)) i_irq_steer_agg (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .addr(addr), .we(we),
      .wdata(wdata), .re(re), .rdata(rdata), .irq_out(irq_out)
   );

   function automatic int a_mask(int n); return 4 + 4 * n; endfunction
   function automatic int a_set(int n);  return 4 * R + 4 + 4 * n; endfunction
   function automatic int a_stat(int n); return 8 * R + 4 + 4 * n; endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(int a, logic [31:0] d);
      @(negedge clk);
      addr = AW'(a); wdata = d; we = 1'b1;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd(int a, output logic [31:0] d);
      @(negedge clk);
      addr = AW'(a); re = 1'b1;
      @(negedge clk);
      re = 1'b0;
      d = rdata;
   endtask

   task automatic settle();
      repeat (5) @(negedge clk);
   endtask

   initial begin
      #(4 * 200000);
      if (!finished) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      chk("R1 irq_out", 32'(irq_out), 32'h0);
      for (int a = 0; a <= A_MST; a += 4) begin
         rd(a, v);
         chk("R1 reg", v, 32'h0);
      end

      // R2: map and readback
      wr(0, 32'h1 << CH);
      rd(0, v); chk("R2 ctrl", v, 32'h1 << CH);
      for (int b = 0; b < R; b++) begin
         wr(a_set(b), 32'hA5A50000 | 32'(b));
         rd(a_set(b), v); chk("R2 set", v, 32'hA5A50000 | 32'(b));
         wr(a_set(b), 32'h0);
         wr(a_mask(b), 32'hFFFFFFFF);
         rd(a_mask(b), v); chk("R2 mask", v, 32'hFFFFFFFF);
      end
      wr(A_DIS, 32'h3);
      rd(A_DIS, v); chk("R2 dis", v, 32'h3);
      wr(A_DIS, 32'h0);
      rd(A_MST + 4, v); chk("R2 unmapped", v, 32'h0);

      // R9: latency input -> output
      @(negedge clk);
      irq_in[0] = 1'b1;
      @(posedge clk); @(posedge clk); #1;
      chk("R9 early", 32'(irq_out), 32'h0);
      @(posedge clk); #1;
      chk("R9 edge2", 32'(irq_out), 32'h1);
      irq_in = '0;
      settle();

      // R3 / R6: sweep of every input
      for (int i = 0; i < N; i++) begin
         @(negedge clk);
         irq_in = '0;
         irq_in[i] = 1'b1;
         settle();
         rd(a_stat(R - 1 - i / 32), v);
         chk("R3 status bank", v, 32'h1 << (i % 32));
         rd(a_stat((R - i / 32) % R), v);
         chk("R3 other bank", v, 32'h0);
         chk("R6 out", 32'(irq_out), 32'h1 << (i / 64));
         rd(A_MST, v);
         chk("R6 mstat", v, 32'h1 << (i / 64));
      end
      irq_in = '0;
      settle();

      // R11: level clear
      chk("R11 out low", 32'(irq_out), 32'h0);
      rd(a_stat(R - 1), v); chk("R11 status clear", v, 32'h0);

      // R4: mask blocks input 5 (bank R-1, bit 5)
      wr(a_mask(R - 1), ~(32'h1 << 5));
      irq_in[5] = 1'b1;
      settle();
      rd(a_stat(R - 1), v); chk("R4 status", v, 32'h0);
      chk("R4 out", 32'(irq_out), 32'h0);
      irq_in = '0;
      wr(a_mask(R - 1), 32'hFFFFFFFF);

      // R5: software set bit 0 of each bank
      for (int b = 0; b < R; b++) begin
         wr(a_set(b), 32'h1);
         settle();
         rd(a_stat(b), v); chk("R5 status", v, 32'h1);
         chk("R5 out", 32'(irq_out), 32'h1 << (((R - 1 - b) * 32) / 64));
         wr(a_set(b), 32'h0);
      end
      settle();

      // R7: disable output 1 while inputs of group 1 active
      irq_in[70] = 1'b1;
      irq_in[3]  = 1'b1;
      wr(A_DIS, 32'h2);
      settle();
      chk("R7 out", 32'(irq_out), 32'h1);
      rd(A_MST, v); chk("R7 mstat", v, 32'h3);
      wr(A_DIS, 32'h0);
      settle();
      chk("R7 released", 32'(irq_out), 32'h3);

      // R8: channel bit gating
      wr(0, ~(32'h1 << CH));
      settle();
      chk("R8 off", 32'(irq_out), 32'h0);
      wr(0, 32'h1 << CH);
      settle();
      chk("R8 on", 32'(irq_out), 32'h3);

      // R10: read-only writes ignored
      wr(a_stat(0), 32'hFFFFFFFF);
      wr(A_MST, 32'hFFFFFFFF);
      rd(a_stat(0), v); chk("R10 status", v, 32'h1 << 6);
      rd(a_mask(0), v); chk("R10 mask", v, 32'hFFFFFFFF);
      rd(a_set(0), v);  chk("R10 set", v, 32'h0);
      rd(A_DIS, v);     chk("R10 dis", v, 32'h0);
      irq_in = '0;
      settle();

      // R11 / R5: input 40 falls in the cycle set bank 1 bit 8 is written
      irq_in[40] = 1'b1;
      settle();
      @(negedge clk);
      addr = AW'(a_set(R - 2)); wdata = 32'h1 << 8; we = 1'b1;
      irq_in[40] = 1'b0;
      @(negedge clk);
      we = 1'b0;
      for (int c = 0; c < 5; c++) begin
         @(negedge clk);
         chk("R11 hold through set", 32'(irq_out), 32'h1);
      end
      rd(a_stat(R - 2), v); chk("R5 status after fall", v, 32'h1 << 8);
      wr(a_set(R - 2), 32'h0);
      settle();
      chk("R11 final clear", 32'(irq_out), 32'h0);

      // R7: disable write issued while a group-1 input rises
      @(negedge clk);
      addr = AW'(A_DIS); wdata = 32'h2; we = 1'b1;
      irq_in[90] = 1'b1;
      @(negedge clk);
      we = 1'b0;
      for (int c = 0; c < 4; c++) begin
         @(negedge clk);
         chk("R7 race out", 32'(irq_out), 32'h0);
      end
      rd(A_MST, v); chk("R7 race mstat", v, 32'h2);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule